// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers playback samples on their way to an audio codec link. A register-bus write port delivers 32-bit data words. Each word becomes one or two 20-bit left-aligned samples, depending on the configured sample width and on whether packed (two samples per word) storage is selected. The samples are then kept in a small circular store. A drain port hands left/right sample pairs to the downstream codec interface under a valid/ready handshake.

A transmit control word, held by a register elsewhere, supplies the configuration. Bit 0 is transmit enable. Bits 1 and 2 are the two slot enables (left slot and right slot). Bits [4:3] give the sample-width code. Bit 5 requests packed mode. A separate interface-enable input empties the store while it is low. The block reports its fill level and four status flags: empty, half-empty, full and underrun.

Draining works in bursts. A burst starts only when the store is at least half full. It then moves consecutive pairs until the consumer refuses one or fewer than two samples remain.

Top module: `atx_sample_fifo`

## Requirements
- R1: Control bits [4:3] select the sample width: code 0 = 16 bits, code 1 = 18 bits, code 2 = 20 bits, code 3 = 12 bits.
- R2: In normal mode a write stores one sample, equal to the data word shifted left by 8 (12-bit), 4 (16-bit), 2 (18-bit) or 0 (20-bit) and truncated to its low 20 bits.
- R3: In packed mode (bit 5 set) a write stores two samples: data bits [15:0] first and bits [31:16] second. Each is shifted left by 8 for the 12-bit code and by 4 otherwise, and truncated to 20 bits.
- R4: A packed-mode request is ignored when the width code is 1 or 2, so the write stores a single normal-mode sample.
- R5: A normal-mode write is dropped when the level equals DEPTH. A packed-mode write is stored only when level + 2 < DEPTH and is otherwise dropped whole. The level never exceeds DEPTH.
- R6: Pairs are offered only while bit 0 and at least one of bits 1 and 2 are set. A burst starts only when the level is at least DEPTH/2.
- R7: After any write, a level above zero clears empty and underrun, a level of at least DEPTH/2 clears half-empty, and a level equal to DEPTH sets full.
- R8: After a drained pair, full is cleared. Half-empty is set if the level is at most DEPTH/2. Empty and underrun are both set if the level is zero.
- R9: Reset, or interface-enable low, empties the store and drops writes. Status then reads level 0, empty 1, half-empty 1, full 0, underrun 0, and no pair is offered.
- R10: Each pair holds the oldest stored sample on pair_left and the next one on pair_right. It leaves the store only on a cycle where pair_valid and pair_ready are both high, and samples leave in the order they were written.
- R11: A cycle with pair_valid high and pair_ready low ends the burst. pair_valid is low on the next cycle, and a new burst needs the level to reach DEPTH/2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable; low empties the store |
| ctrl_word | input | 6 | Transmit control word (enable, slot enables, width code, packed request) |
| wr_valid | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word |
| pair_valid | output | 1 | A left/right pair is offered |
| pair_ready | input | 1 | Consumer accepts the offered pair |
| pair_left | output | 20 | Left sample of the pair |
| pair_right | output | 20 | Right sample of the pair |
| fill_level | output | $clog2(DEPTH+1) | Number of stored samples |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
A corrupted pointer or storage bank shows up at the ports as a wrong or reordered sample on the first pair drained after the fault. The scoreboard compares every handed-out pair against the samples the bench predicted at write time, so such an error is caught on that same handshake. A wrong level shows on fill_level one cycle after the write or drain that caused it. It also shifts the burst start and the flag edges by whole samples, which the threshold, drop and flag checks observe directly. A missing burst stop after a refusal shows as pair_valid staying high, or as the level dropping below DEPTH/2 without a new threshold crossing.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int SAMPLE_W = 20;
  localparam int WORD_W   = 32;
  localparam int CTRL_W   = 6;

  // width code field, bits [4:3] of the control word
  typedef enum logic [1:0] {
    WCODE_16 = 2'd0,
    WCODE_18 = 2'd1,
    WCODE_20 = 2'd2,
    WCODE_12 = 2'd3
  } width_code_e;

  // packed: first member is the most significant bit (bit 5)
  typedef struct packed {
    logic        pack_req;   // bit 5
    width_code_e width;      // bits [4:3]
    logic        slot_r_en;  // bit 2
    logic        slot_l_en;  // bit 1
    logic        tx_en;      // bit 0
  } tx_ctrl_t;

  typedef struct packed {
    logic empty;
    logic half_empty;
    logic full;
    logic underrun;
  } tx_flags_t;
endpackage

// File: rtl/atx_width_norm.sv
module atx_width_norm
  import atx_pkg::*;
(
  input  tx_ctrl_t              ctrl,
  input  logic [WORD_W-1:0]     word,
  output logic [SAMPLE_W-1:0]   samp_first,
  output logic [SAMPLE_W-1:0]   samp_second,
  output logic                  two_samples
);
  logic [3:0]          norm_shift;
  logic [3:0]          pack_shift;
  logic                pack_allowed;
  logic [SAMPLE_W-1:0] norm_samp;
  logic [SAMPLE_W-1:0] pack_lo;
  logic [SAMPLE_W-1:0] pack_hi;

  // packing only exists for 12- and 16-bit widths
  assign pack_allowed = (ctrl.width == WCODE_16) || (ctrl.width == WCODE_12);
  assign two_samples  = ctrl.pack_req && pack_allowed;

  always_comb begin
    unique case (ctrl.width)
      WCODE_12: norm_shift = 4'd8;
      WCODE_16: norm_shift = 4'd4;
      WCODE_18: norm_shift = 4'd2;
      default:  norm_shift = 4'd0;
    endcase
    pack_shift = (ctrl.width == WCODE_12) ? 4'd8 : 4'd4;
  end

  // shifting inside a 20-bit container performs the truncation
  assign norm_samp = word[SAMPLE_W-1:0] << norm_shift;
  assign pack_lo   = SAMPLE_W'(word[15:0])  << pack_shift;
  assign pack_hi   = SAMPLE_W'(word[31:16]) << pack_shift;

  assign samp_first  = two_samples ? pack_lo : norm_samp;
  assign samp_second = pack_hi;

  always_comb begin
    AST_PACK_ONLY_NARROW: assert (!(two_samples &&
      (ctrl.width == WCODE_18 || ctrl.width == WCODE_20))); // R4
  end
endmodule

// File: rtl/atx_pair_store.sv
module atx_pair_store
  import atx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int HD   = DEPTH / 2,
  localparam int HAW  = AW - 1
)(
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_two,
  input  logic [AW-1:0]       wr_ptr,
  input  logic [SAMPLE_W-1:0] wr_first,
  input  logic [SAMPLE_W-1:0] wr_second,
  input  logic [HAW-1:0]      rd_row,
  output logic [SAMPLE_W-1:0] rd_left,
  output logic [SAMPLE_W-1:0] rd_right
);
  // even entries live in bank 0, odd entries in bank 1; every bank
  // takes at most one write per cycle, so each infers a simple RAM
  logic [AW-1:0]  next_ptr;
  logic [HAW-1:0] row_first;
  logic [HAW-1:0] row_second;
  logic [1:0][SAMPLE_W-1:0] bank_rd;

  assign next_ptr   = wr_ptr + AW'(1);
  assign row_first  = wr_ptr[AW-1:1];
  assign row_second = next_ptr[AW-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SAMPLE_W-1:0] mem [HD];
    logic                we;
    logic [HAW-1:0]      waddr;
    logic [SAMPLE_W-1:0] wdata;

    always_comb begin
      if (wr_ptr[0] == 1'(b)) begin
        we    = wr_en;
        waddr = row_first;
        wdata = wr_first;
      end else begin
        we    = wr_en && wr_two;
        waddr = row_second;
        wdata = wr_second;
      end
    end

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
    end

    assign bank_rd[b] = mem[rd_row];
  end

  assign rd_left  = bank_rd[0];
  assign rd_right = bank_rd[1];
endmodule

// File: rtl/atx_fill_ctrl.sv
module atx_fill_ctrl
  import atx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int HAW  = AW - 1
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            iface_en,
  input  logic            drain_ok,
  input  logic            wr_req,
  input  logic            wr_two,
  input  logic            pair_ready,
  output logic            push,
  output logic [AW-1:0]   wr_ptr,
  output logic [HAW-1:0]  rd_row,
  output logic [LW-1:0]   level,
  output tx_flags_t       flags,
  output logic            pair_valid
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TWO_L   = LW'(2);
  localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);

  logic            burst_q;
  logic            burst_d;
  logic            pop;
  logic            wr_seen;
  logic [LW:0]     level_p2;
  logic [LW-1:0]   push_n;
  logic [LW-1:0]   lvl_w;
  logic [LW-1:0]   lvl_f;
  tx_flags_t       flags_d;

  assign wr_seen  = wr_req && iface_en;
  assign level_p2 = {1'b0, level} + (LW+1)'(2);
  assign push     = wr_seen && (wr_two ? (level_p2 < DEPTH_X) : (level < DEPTH_L));
  assign push_n   = push ? (wr_two ? TWO_L : LW'(1)) : '0;

  assign pair_valid = burst_q && drain_ok && (level >= TWO_L);
  assign pop        = pair_valid && pair_ready;

  // write effect first, then drain effect, as one atomic update
  assign lvl_w = level + push_n;
  assign lvl_f = lvl_w - (pop ? TWO_L : '0);

  always_comb begin
    flags_d = flags;
    if (wr_seen) begin
      if (lvl_w != '0) begin
        flags_d.empty    = 1'b0;
        flags_d.underrun = 1'b0;
      end
      if (lvl_w >= HALF_L)  flags_d.half_empty = 1'b0;
      if (lvl_w >= DEPTH_L) flags_d.full       = 1'b1;
    end
    if (pop) begin
      flags_d.full = 1'b0;
      if (lvl_f <= HALF_L) flags_d.half_empty = 1'b1;
      if (lvl_f == '0) begin
        flags_d.empty    = 1'b1;
        flags_d.underrun = 1'b1;
      end
    end
  end

  always_comb begin
    if (!iface_en || !drain_ok) begin
      burst_d = 1'b0;
    end else if (!burst_q) begin
      burst_d = (level >= HALF_L);
    end else if (pair_valid && !pair_ready) begin
      burst_d = 1'b0;
    end else if (pop && (lvl_f < TWO_L)) begin
      burst_d = 1'b0;
    end else begin
      burst_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !iface_en) begin
      level   <= '0;
      wr_ptr  <= '0;
      rd_row  <= '0;
      burst_q <= 1'b0;
      flags   <= '{empty: 1'b1, half_empty: 1'b1, full: 1'b0, underrun: 1'b0};
    end else begin
      level   <= lvl_f;
      flags   <= flags_d;
      burst_q <= burst_d;
      if (push) wr_ptr <= wr_ptr + (wr_two ? AW'(2) : AW'(1));
      if (pop)  rd_row <= rd_row + HAW'(1);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_L); // R5
  AST_DROP_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (iface_en && wr_req && !wr_two && level == DEPTH_L && !pop) |=> level == DEPTH_L); // R5
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flags.full == (level == DEPTH_L)); // R7
  AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flags.empty == (level == '0)); // R8
  AST_FLUSH_STATE: assert property (@(posedge clk) disable iff (rst)
    !iface_en |=> (level == '0 && flags.empty && flags.half_empty &&
                   !flags.full && !flags.underrun && !pair_valid)); // R9
  AST_REFUSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !pair_ready) |=> !pair_valid); // R11
endmodule

// File: rtl/atx_sample_fifo.sv
module atx_sample_fifo
  import atx_pkg::*;
#(
  parameter int DEPTH = 8
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         iface_en,
  input  logic [5:0]                   ctrl_word,
  input  logic                         wr_valid,
  input  logic [31:0]                  wr_data,
  output logic                         pair_valid,
  input  logic                         pair_ready,
  output logic [19:0]                  pair_left,
  output logic [19:0]                  pair_right,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic                         st_empty,
  output logic                         st_half_empty,
  output logic                         st_full,
  output logic                         st_underrun
);
  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int HAW = AW - 1;

  tx_ctrl_t            ctrl;
  logic                drain_ok;
  logic                two;
  logic                push;
  logic [SAMPLE_W-1:0] s_first;
  logic [SAMPLE_W-1:0] s_second;
  logic [AW-1:0]       wr_ptr;
  logic [HAW-1:0]      rd_row;
  logic [LW-1:0]       level;
  tx_flags_t           flags;

  assign ctrl     = tx_ctrl_t'(ctrl_word);
  assign drain_ok = ctrl.tx_en && (ctrl.slot_l_en || ctrl.slot_r_en);

  atx_width_norm u_norm (
    .ctrl        (ctrl),
    .word        (wr_data),
    .samp_first  (s_first),
    .samp_second (s_second),
    .two_samples (two)
  );

  atx_fill_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .iface_en   (iface_en),
    .drain_ok   (drain_ok),
    .wr_req     (wr_valid),
    .wr_two     (two),
    .pair_ready (pair_ready),
    .push       (push),
    .wr_ptr     (wr_ptr),
    .rd_row     (rd_row),
    .level      (level),
    .flags      (flags),
    .pair_valid (pair_valid)
  );

  atx_pair_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en     (push),
    .wr_two    (two),
    .wr_ptr    (wr_ptr),
    .wr_first  (s_first),
    .wr_second (s_second),
    .rd_row    (rd_row),
    .rd_left   (pair_left),
    .rd_right  (pair_right)
  );

  assign fill_level    = level;
  assign st_empty      = flags.empty;
  assign st_half_empty = flags.half_empty;
  assign st_full       = flags.full;
  assign st_underrun   = flags.underrun;

  AST_DRAIN_GATED: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (ctrl_word[0] && (ctrl_word[1] || ctrl_word[2]))); // R6
  AST_START_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    ($rose(pair_valid) && $past(drain_ok)) |-> $past(fill_level) >= LW'(DEPTH / 2)); // R6
endmodule

// File: tb/atx_sample_fifo_bench.sv
module atx_sample_fifo_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iface_en = 1'b1;
  logic [5:0]  ctrl_word = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pair_valid;
  logic        pair_ready = 1'b0;
  logic [19:0] pair_left;
  logic [19:0] pair_right;
  logic [3:0]  fill_level;
  logic        st_empty, st_half_empty, st_full, st_underrun;

  int checks = 0;
  int errors = 0;
  int pairs_seen = 0;
  bit done = 1'b0;
  logic [19:0] expq[$];

  always #2 clk = ~clk;  // 250 MHz

  atx_sample_fifo #(.DEPTH(DEPTH)) u_atx_sample_fifo (
    .clk(clk), .rst(rst), .iface_en(iface_en), .ctrl_word(ctrl_word),
    .wr_valid(wr_valid), .wr_data(wr_data), .pair_valid(pair_valid),
    .pair_ready(pair_ready), .pair_left(pair_left), .pair_right(pair_right),
    .fill_level(fill_level), .st_empty(st_empty), .st_half_empty(st_half_empty),
    .st_full(st_full), .st_underrun(st_underrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mk_ctrl(bit tx, bit sl, bit sr, logic [1:0] code, bit pk);
    return {pk, code, sr, sl, tx};
  endfunction

  // normal-mode expectation: multiply instead of shift
  function automatic logic [19:0] exp_norm(logic [1:0] code, logic [31:0] v);
    logic [31:0] r;
    case (code)
      2'd0: r = v * 32'd16;
      2'd1: r = v * 32'd4;
      2'd2: r = v;
      default: r = v * 32'd256;
    endcase
    return r[19:0];
  endfunction

  function automatic logic [19:0] exp_pack(logic [1:0] code, logic [15:0] h);
    logic [31:0] r;
    r = {16'h0, h} * ((code == 2'd3) ? 32'd256 : 32'd16);
    return r[19:0];
  endfunction

  // driver: predicts, enqueues, then strobes one word
  task automatic do_write(input logic [31:0] w);
    logic [1:0] code;
    bit pk;
    int lvl;
    code = ctrl_word[4:3];
    pk   = ctrl_word[5] && (code == 2'd0 || code == 2'd3);
    lvl  = expq.size();
    if (iface_en) begin
      if (pk && (lvl + 2 < DEPTH)) begin
        expq.push_back(exp_pack(code, w[15:0]));
        expq.push_back(exp_pack(code, w[31:16]));
      end else if (!pk && lvl < DEPTH) begin
        expq.push_back(exp_norm(code, w));
      end
    end
    wr_data  = w;
    wr_valid = 1'b1;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  // monitor: every accepted pair is compared with the two oldest predictions (R10)
  always @(negedge clk) begin
    if (!rst && pair_valid && pair_ready) begin
      if (expq.size() < 2) begin
        check(1'b0, "R10 pair with no prediction", 32'(expq.size()), 32'd2);
      end else begin
        check(pair_left == expq[0], "R10 left sample", 32'(pair_left), 32'(expq[0]));
        check(pair_right == expq[1], "R10 right sample", 32'(pair_right), 32'(expq[1]));
        void'(expq.pop_front());
        void'(expq.pop_front());
      end
      pairs_seen++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] words [8];
    int p0;
    words[0] = 32'h0001_2345; words[1] = 32'h0003_FFFF;
    words[2] = 32'hFFF1_2345; words[3] = 32'h0000_0ABC;
    words[4] = 32'h0000_FFFF; words[5] = 32'h0001_5555;
    words[6] = 32'h000A_BCDE; words[7] = 32'h0000_0123;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(fill_level == 0 && st_empty && st_half_empty && !st_full && !st_underrun && !pair_valid,
          "R9 reset state", {fill_level, st_empty, st_half_empty, st_full, st_underrun},
          {4'd0, 4'b1100});

    // R1 R2: fill with drain disabled, rotating the width code
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      ctrl_word = mk_ctrl(0, 0, 0, 2'(i % 4), 0);
      do_write(words[i]);
      @(negedge clk);
      check(fill_level == 4'(i + 1), "R2 level after normal write", 32'(fill_level), 32'(i + 1));
      if (i == 0) check(!st_empty && !st_underrun && st_half_empty, "R7 first write flags",
                        {st_empty, st_underrun, st_half_empty}, 3'b001);
      if (i == 3) check(!st_half_empty, "R7 half-empty cleared at DEPTH/2", 32'(st_half_empty), 0);
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(st_full, "R7 full at DEPTH", 32'(st_full), 1);
    @(posedge clk); #1;
    do_write(32'h000F_FFFF);
    @(negedge clk);
    check(fill_level == 8, "R5 normal write dropped when full", 32'(fill_level), 8);

    // R10 R8: drain everything
    @(posedge clk); #1;
    p0 = pairs_seen;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd0, 0);
    pair_ready = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(pairs_seen - p0 == 4, "R10 all pairs drained", 32'(pairs_seen - p0), 4);
    check(fill_level == 0 && st_empty && st_underrun && st_half_empty && !st_full,
          "R8 flags after full drain", {fill_level, st_empty, st_underrun, st_half_empty, st_full},
          {4'd0, 4'b1110});

    // R3 R4 R5: packed mode with drain off
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(0, 0, 0, 2'd0, 1);
    do_write(32'hABCD_1234);
    @(negedge clk);
    check(fill_level == 2, "R3 packed 16-bit stores two", 32'(fill_level), 2);
    check(!st_underrun && !st_empty, "R7 write clears underrun", {st_underrun, st_empty}, 0);
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(0, 0, 0, 2'd3, 1);
    do_write(32'h0FFF_0ABC);
    do_write(32'h1111_2222);
    @(negedge clk);
    check(fill_level == 6, "R3 packed 12-bit stores two", 32'(fill_level), 6);
    @(posedge clk); #1;
    do_write(32'h3333_4444);
    @(negedge clk);
    check(fill_level == 6, "R5 packed write dropped whole", 32'(fill_level), 6);
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(0, 0, 0, 2'd2, 1);
    do_write(32'hFF0A_BCDE);
    @(negedge clk);
    check(fill_level == 7, "R4 packing ignored for 20-bit", 32'(fill_level), 7);
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(0, 0, 0, 2'd1, 1);
    do_write(32'h0003_FFFF);
    @(negedge clk);
    check(fill_level == 8, "R4 packing ignored for 18-bit", 32'(fill_level), 8);
    @(posedge clk); #1;
    p0 = pairs_seen;
    ctrl_word = mk_ctrl(1, 0, 1, 2'd0, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(pairs_seen - p0 == 4 && fill_level == 0, "R3 packed order drained", 32'(pairs_seen - p0), 4);

    // R6: threshold, drain enabled, ready high
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) do_write(32'(i + 16'h100));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!pair_valid && fill_level == 3, "R6 no burst below DEPTH/2", 32'(fill_level), 3);
    @(posedge clk); #1;
    do_write(32'h0000_0777);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(fill_level == 0, "R6 burst starts at DEPTH/2", 32'(fill_level), 0);

    // R6: slot enables both off block draining
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(1, 0, 0, 2'd0, 0);
    for (int i = 0; i < 4; i++) do_write(32'(i + 16'h200));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!pair_valid && fill_level == 4, "R6 no slot enable no drain", 32'(fill_level), 4);

    // R11: one pair accepted, then a refusal ends the burst
    @(posedge clk); #1;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd0, 0);
    pair_ready = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 pair_ready = 1'b0;
    @(negedge clk);
    check(pair_valid && fill_level == 2, "R11 pair offered while refused", {pair_valid, fill_level}, {1'b1, 4'd2});
    check(st_half_empty && !st_empty, "R8 half-empty set after partial drain",
          {st_half_empty, st_empty}, 2'b10);
    @(posedge clk);
    #1 pair_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!pair_valid && fill_level == 2, "R11 burst ended by refusal", {pair_valid, fill_level}, {1'b0, 4'd2});

    // R9: interface disable flushes and drops writes
    @(posedge clk); #1;
    iface_en = 1'b0;
    do_write(32'h0000_1234);
    expq.delete();
    @(negedge clk);
    check(fill_level == 0 && st_empty && st_half_empty && !st_full && !st_underrun && !pair_valid,
          "R9 flush and write dropped", {fill_level, st_empty, st_half_empty, st_full, st_underrun},
          {4'd0, 4'b1100});
    @(posedge clk); #1;
    iface_en = 1'b1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule